// File: doc/BRIEF.md
# Expansion Chassis Slot Gateway

This block is the control logic of a chassis that carries a host computer's peripheral slots over a cable into a separate box. It bridges the host's 8-bit data bus and 16-bit address bus onto the remote slots. The data direction follows the host read/write line. A 3-bit slot number is decoded into two matching sets of per-slot strobes: device-select and I/O-select. Interrupt and DMA priority are passed from slot to slot as daisy chains. The host's phase clocks are re-driven to the slots.

A registered select state gates the bus bridge and both slot decoders together. When the box is deselected, every slot disappears from the host at once. The bus outputs are given as separate value and enable signals, so the pad ring places the high-impedance drivers. An output whose enable is low carries zero.

Top module: `slot_xgate`

## Requirements
- R1: After the active-low reset `rst_n`, `box_sel_o` is 0, every bus enable (`host_data_oe_o`, `slot_data_oe_o`, both bits of `slot_addr_oe_o`) is 0, and every bit of `dev_sel_n_o` and `io_sel_n_o` is 1.
- R2: At a rising clock edge, `desel_req_i`=1 clears the select state to deselected. Otherwise `sel_req_i`=1 sets it to selected. Otherwise it holds. The new state shows on `box_sel_o` after that edge.
- R3: While deselected, all bus enables are 0 and all bus value outputs (`host_data_o`, `slot_data_o`, `slot_addr_o`) are 0, whatever the other bus inputs are.
- R4: While selected with `host_rw_i`=0 (write), `slot_data_o` equals `host_data_i`, `slot_data_oe_o`=1, `host_data_oe_o`=0 and `host_data_o`=0.
- R5: While selected with `host_rw_i`=1 (read), `host_data_o` equals `slot_data_i`, `host_data_oe_o`=1, `slot_data_oe_o`=0 and `slot_data_o`=0.
- R6: While selected, `slot_addr_o` equals `host_addr_i`. `slot_addr_oe_o` bit 0 enables address bits 7:0 and bit 1 enables bits 15:8, and both bits are 1.
- R7: While selected with `access_i`=1, bit `slot_num_i` of `dev_sel_n_o` is 0 and all its other bits are 1 (active-low, one-hot).
- R8: `io_sel_n_o` always equals `dev_sel_n_o`, so one access strobes both lines of the same slot.
- R9: When deselected or with `access_i`=0, all bits of `dev_sel_n_o` and `io_sel_n_o` are 1.
- R10: Interrupt chain (active-high pass-on): `int_slot_in_o[0]` = `int_head_i`. Each slot k passes `int_slot_in_o[k] & ~int_claim_i[k]` on to slot k+1 (or to `int_tail_o` after slot 7). The outputs change combinationally.
- R11: The DMA chain follows the same rule as R10, using `dma_head_i`, `dma_claim_i`, `dma_slot_in_o` and `dma_tail_o`.
- R12: `phi0_o`, `phi1_o`, `q3_o` and `clk7m_o` follow `phi0_i`, `phi1_i`, `q3_i` and `clk7m_i` in the same cycle, whatever the select state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the select register |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_req_i | input | 1 | Request to enter the selected state |
| desel_req_i | input | 1 | Request to enter the deselected state (wins) |
| box_sel_o | output | 1 | Current select state |
| host_rw_i | input | 1 | Host read/write, 1 = read, 0 = write |
| access_i | input | 1 | Host is making a slot access |
| slot_num_i | input | 3 | Slot being accessed |
| host_addr_i | input | 16 | Host address bus |
| host_data_i | input | 8 | Host data bus, inbound |
| host_data_o | output | 8 | Data driven back to the host |
| host_data_oe_o | output | 1 | Enable for host-side data driver |
| slot_addr_o | output | 16 | Address to the slots |
| slot_addr_oe_o | output | 2 | Enable per address half (bit 0 low half) |
| slot_data_i | input | 8 | Data bus from the slots |
| slot_data_o | output | 8 | Data driven to the slots |
| slot_data_oe_o | output | 1 | Enable for slot-side data driver |
| dev_sel_n_o | output | 8 | Active-low device-select per slot |
| io_sel_n_o | output | 8 | Active-low I/O-select per slot |
| int_head_i | input | 1 | Interrupt chain entry |
| int_claim_i | input | 8 | Per-slot interrupt claim |
| int_slot_in_o | output | 8 | Interrupt chain input seen by each slot |
| int_tail_o | output | 1 | Interrupt chain exit after the last slot |
| dma_head_i | input | 1 | DMA chain entry |
| dma_claim_i | input | 8 | Per-slot DMA claim |
| dma_slot_in_o | output | 8 | DMA chain input seen by each slot |
| dma_tail_o | output | 1 | DMA chain exit after the last slot |
| phi0_i | input | 1 | Phase 0 clock from host |
| phi1_i | input | 1 | Phase 1 clock from host |
| q3_i | input | 1 | Q3 clock from host |
| clk7m_i | input | 1 | 7M clock from host |
| phi0_o | output | 1 | Re-driven phase 0 |
| phi1_o | output | 1 | Re-driven phase 1 |
| q3_o | output | 1 | Re-driven Q3 |
| clk7m_o | output | 1 | Pass-through 7M |

## Verification
The bench raises select and deselect requests together to catch a design that lets select win, which would leave the slots visible. It drives bus traffic, and flips the read/write line, while deselected. A gate that leaked would then show nonzero enables or values, and a bridge that ignored direction would enable both data drivers or move the wrong bus. It sweeps every slot number with access on and off to expose decoders that split apart, select the wrong slot, or strobe without a qualified access. It applies chain claim patterns with none, one, several and all slots claiming, so a chain that fails to break at the first claim, or breaks one slot late, shows at the per-slot inputs and the tail.

// File: rtl/xg_pkg.sv
package xg_pkg;
   // Bridge direction for the data bus.
   typedef enum logic {
      XG_TO_SLOTS = 1'b0,
      XG_TO_HOST  = 1'b1
   } xg_dir_e;

   // Which strobe family a decoder instance produces.
   typedef enum logic {
      XG_DEV_STROBE = 1'b0,
      XG_IO_STROBE  = 1'b1
   } xg_strobe_e;

   localparam int unsigned XG_STROBE_KINDS = 2;
endpackage

// File: rtl/xg_sel_reg.sv
module xg_sel_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic sel_o
);
   logic sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sel_q <= 1'b0;
      else if (clr_i) sel_q <= 1'b0;
      else if (set_i) sel_q <= 1'b1;
   end

   assign sel_o = sel_q;
endmodule

// File: rtl/xg_bus_gate.sv
module xg_bus_gate
   import xg_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned HALF_W = 8
) (
   input  logic                       en_i,
   input  xg_dir_e                    dir_i,
   input  logic [ADDR_W-1:0]          host_addr_i,
   input  logic [DATA_W-1:0]          host_data_i,
   output logic [DATA_W-1:0]          host_data_o,
   output logic                       host_data_oe_o,
   output logic [ADDR_W-1:0]          slot_addr_o,
   output logic [ADDR_W/HALF_W-1:0]   slot_addr_oe_o,
   input  logic [DATA_W-1:0]          slot_data_i,
   output logic [DATA_W-1:0]          slot_data_o,
   output logic                       slot_data_oe_o
);
   localparam int unsigned N_HALVES = ADDR_W / HALF_W;

   if ((ADDR_W % HALF_W) != 0) begin : g_bad_split
      $error("xg_bus_gate: ADDR_W must be a multiple of HALF_W");
   end

   // Address: each half has its own gate, all driven by one enable.
   for (genvar h = 0; h < N_HALVES; h++) begin : g_half
      assign slot_addr_oe_o[h] = en_i;
      assign slot_addr_o[h*HALF_W +: HALF_W] =
         en_i ? host_addr_i[h*HALF_W +: HALF_W] : '0;
   end

   // Data: exactly one side drives, picked by direction.
   logic to_slots, to_host;
   always_comb begin
      to_slots = en_i && (dir_i == XG_TO_SLOTS);
      to_host  = en_i && (dir_i == XG_TO_HOST);
   end

   assign slot_data_oe_o = to_slots;
   assign host_data_oe_o = to_host;
   assign slot_data_o    = to_slots ? host_data_i : '0;
   assign host_data_o    = to_host  ? slot_data_i : '0;
endmodule

// File: rtl/xg_slot_dec.sv
module xg_slot_dec #(
   parameter int unsigned N_SLOTS = 8,
   localparam int unsigned SEL_W  = $clog2(N_SLOTS)
) (
   input  logic               en_i,
   input  logic [SEL_W-1:0]   num_i,
   output logic [N_SLOTS-1:0] strobe_n_o
);
   if ((1 << SEL_W) != N_SLOTS) begin : g_bad_count
      $error("xg_slot_dec: N_SLOTS must be a power of two");
   end

   for (genvar s = 0; s < N_SLOTS; s++) begin : g_line
      assign strobe_n_o[s] = !(en_i && (num_i == SEL_W'(s)));
   end
endmodule

// File: rtl/xg_prio_chain.sv
module xg_prio_chain #(
   parameter int unsigned N_SLOTS = 8
) (
   input  logic               head_i,
   input  logic [N_SLOTS-1:0] claim_i,
   output logic [N_SLOTS-1:0] slot_in_o,
   output logic               tail_o
);
   // Each slot sees the head only if no earlier slot has claimed.
   for (genvar s = 0; s < N_SLOTS; s++) begin : g_link
      if (s == 0) begin : g_first
         assign slot_in_o[s] = head_i;
      end else begin : g_rest
         assign slot_in_o[s] = head_i && !(|claim_i[s-1:0]);
      end
   end

   assign tail_o = head_i && !(|claim_i);
endmodule

// File: rtl/slot_xgate.sv
module slot_xgate
   import xg_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned HALF_W  = 8,
   parameter int unsigned N_SLOTS = 8,
   localparam int unsigned SEL_W  = $clog2(N_SLOTS),
   localparam int unsigned N_HALVES = ADDR_W / HALF_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sel_req_i,
   input  logic                 desel_req_i,
   output logic                 box_sel_o,
   input  logic                 host_rw_i,
   input  logic                 access_i,
   input  logic [SEL_W-1:0]     slot_num_i,
   input  logic [ADDR_W-1:0]    host_addr_i,
   input  logic [DATA_W-1:0]    host_data_i,
   output logic [DATA_W-1:0]    host_data_o,
   output logic                 host_data_oe_o,
   output logic [ADDR_W-1:0]    slot_addr_o,
   output logic [N_HALVES-1:0]  slot_addr_oe_o,
   input  logic [DATA_W-1:0]    slot_data_i,
   output logic [DATA_W-1:0]    slot_data_o,
   output logic                 slot_data_oe_o,
   output logic [N_SLOTS-1:0]   dev_sel_n_o,
   output logic [N_SLOTS-1:0]   io_sel_n_o,
   input  logic                 int_head_i,
   input  logic [N_SLOTS-1:0]   int_claim_i,
   output logic [N_SLOTS-1:0]   int_slot_in_o,
   output logic                 int_tail_o,
   input  logic                 dma_head_i,
   input  logic [N_SLOTS-1:0]   dma_claim_i,
   output logic [N_SLOTS-1:0]   dma_slot_in_o,
   output logic                 dma_tail_o,
   input  logic                 phi0_i,
   input  logic                 phi1_i,
   input  logic                 q3_i,
   input  logic                 clk7m_i,
   output logic                 phi0_o,
   output logic                 phi1_o,
   output logic                 q3_o,
   output logic                 clk7m_o
);
   if (DATA_W == 0 || N_SLOTS < 2) begin : g_bad_param
      $error("slot_xgate: DATA_W must be nonzero and N_SLOTS at least 2");
   end

   logic    selected;
   logic    dec_en;
   xg_dir_e dir;

   xg_sel_reg u_sel (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (sel_req_i),
      .clr_i (desel_req_i),
      .sel_o (selected)
   );

   assign box_sel_o = selected;
   assign dir       = host_rw_i ? XG_TO_HOST : XG_TO_SLOTS;
   assign dec_en    = selected && access_i;

   xg_bus_gate #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .HALF_W (HALF_W)
   ) u_gate (
      .en_i           (selected),
      .dir_i          (dir),
      .host_addr_i    (host_addr_i),
      .host_data_i    (host_data_i),
      .host_data_o    (host_data_o),
      .host_data_oe_o (host_data_oe_o),
      .slot_addr_o    (slot_addr_o),
      .slot_addr_oe_o (slot_addr_oe_o),
      .slot_data_i    (slot_data_i),
      .slot_data_o    (slot_data_o),
      .slot_data_oe_o (slot_data_oe_o)
   );

   // Two decoders tied to the same select bits, one per strobe family.
   logic [N_SLOTS-1:0] strobes_n [XG_STROBE_KINDS];

   for (genvar k = 0; k < XG_STROBE_KINDS; k++) begin : g_dec
      xg_slot_dec #(.N_SLOTS(N_SLOTS)) u_dec (
         .en_i       (dec_en),
         .num_i      (slot_num_i),
         .strobe_n_o (strobes_n[k])
      );
   end

   assign dev_sel_n_o = strobes_n[XG_DEV_STROBE];
   assign io_sel_n_o  = strobes_n[XG_IO_STROBE];

   xg_prio_chain #(.N_SLOTS(N_SLOTS)) u_int_chain (
      .head_i    (int_head_i),
      .claim_i   (int_claim_i),
      .slot_in_o (int_slot_in_o),
      .tail_o    (int_tail_o)
   );

   xg_prio_chain #(.N_SLOTS(N_SLOTS)) u_dma_chain (
      .head_i    (dma_head_i),
      .claim_i   (dma_claim_i),
      .slot_in_o (dma_slot_in_o),
      .tail_o    (dma_tail_o)
   );

   // Phase clocks re-driven, 7M passed straight on.
   assign phi0_o  = phi0_i;
   assign phi1_o  = phi1_i;
   assign q3_o    = q3_i;
   assign clk7m_o = clk7m_i;
endmodule

// File: rtl/slot_xgate_chk.sv
module slot_xgate_chk #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned HALF_W  = 8,
   parameter int unsigned N_SLOTS = 8,
   localparam int unsigned SEL_W  = $clog2(N_SLOTS),
   localparam int unsigned N_HALVES = ADDR_W / HALF_W
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sel_req_i,
   input logic                desel_req_i,
   input logic                box_sel_o,
   input logic                host_rw_i,
   input logic                access_i,
   input logic [SEL_W-1:0]    slot_num_i,
   input logic [DATA_W-1:0]   host_data_i,
   input logic                host_data_oe_o,
   input logic [N_HALVES-1:0] slot_addr_oe_o,
   input logic [DATA_W-1:0]   slot_data_o,
   input logic                slot_data_oe_o,
   input logic [N_SLOTS-1:0]  dev_sel_n_o,
   input logic [N_SLOTS-1:0]  io_sel_n_o,
   input logic                int_head_i,
   input logic                int_tail_o,
   input logic                dma_head_i,
   input logic                dma_tail_o
);
   // R2
   sel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_req_i && !desel_req_i) |=> box_sel_o);

   // R2
   sel_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      desel_req_i |=> !box_sel_o);

   // R3
   hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !box_sel_o |-> (!host_data_oe_o && !slot_data_oe_o && slot_addr_oe_o == '0));

   // R4
   write_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (box_sel_o && !host_rw_i) |-> (slot_data_oe_o && !host_data_oe_o
                                     && slot_data_o == host_data_i));

   // R5
   read_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (box_sel_o && host_rw_i) |-> (host_data_oe_o && !slot_data_oe_o));

   // R7
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (box_sel_o && access_i) |-> ($countones(~dev_sel_n_o) == 1 && !dev_sel_n_o[slot_num_i]));

   // R8
   lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_sel_n_o == io_sel_n_o);

   // R9
   idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!box_sel_o || !access_i) |-> (&dev_sel_n_o && &io_sel_n_o));

   // R10
   int_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_tail_o |-> int_head_i);

   // R11
   dma_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_tail_o |-> dma_head_i);
endmodule

bind slot_xgate slot_xgate_chk #(
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .HALF_W  (HALF_W),
   .N_SLOTS (N_SLOTS)
) chk_i (.*);

// File: tb/slot_xgate_tb_top.sv
module slot_xgate_tb_top;
   localparam int CLK_HALF = 4;   // 125 MHz
   localparam int NS = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_req = 0, desel_req = 0, rw = 0, acc = 0;
   logic [2:0]  snum = 0;
   logic [15:0] haddr = 0;
   logic [7:0]  hdata = 0, sdata = 0;
   logic int_head = 0, dma_head = 0;
   logic [7:0] int_claim = 0, dma_claim = 0;
   logic phi0 = 0, phi1 = 0, q3 = 0, c7m = 0;

   logic        box_sel, h_oe, s_oe, int_tail, dma_tail;
   logic [7:0]  h_out, s_out, dev_n, io_n, int_in, dma_in;
   logic [15:0] a_out;
   logic [1:0]  a_oe;
   logic phi0_o, phi1_o, q3_o, c7m_o;

   int total = 0, bad = 0;
   bit ref_sel = 0;

   always #CLK_HALF clk = ~clk;

   slot_xgate dut_i (
      .clk(clk), .rst_n(rst_n), .sel_req_i(sel_req), .desel_req_i(desel_req),
      .box_sel_o(box_sel), .host_rw_i(rw), .access_i(acc), .slot_num_i(snum),
      .host_addr_i(haddr), .host_data_i(hdata), .host_data_o(h_out),
      .host_data_oe_o(h_oe), .slot_addr_o(a_out), .slot_addr_oe_o(a_oe),
      .slot_data_i(sdata), .slot_data_o(s_out), .slot_data_oe_o(s_oe),
      .dev_sel_n_o(dev_n), .io_sel_n_o(io_n),
      .int_head_i(int_head), .int_claim_i(int_claim), .int_slot_in_o(int_in),
      .int_tail_o(int_tail), .dma_head_i(dma_head), .dma_claim_i(dma_claim),
      .dma_slot_in_o(dma_in), .dma_tail_o(dma_tail),
      .phi0_i(phi0), .phi1_i(phi1), .q3_i(q3), .clk7m_i(c7m),
      .phi0_o(phi0_o), .phi1_o(phi1_o), .q3_o(q3_o), .clk7m_o(c7m_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference for the chain: walk slots, stop at first claim.
   task automatic chain_ref(input logic head, input logic [7:0] claim,
                            output logic [7:0] ins, output logic tail);
      logic live = head;
      for (int s = 0; s < NS; s++) begin
         ins[s] = live;
         if (claim[s]) live = 1'b0;
      end
      tail = live;
   endtask

   task automatic compare_all();
      logic [7:0] e_strobe, e_int, e_dma;
      logic e_it, e_dt;
      e_strobe = 8'hFF;
      if (ref_sel && acc) e_strobe[snum] = 1'b0;
      chain_ref(int_head, int_claim, e_int, e_it);
      chain_ref(dma_head, dma_claim, e_dma, e_dt);

      chk(box_sel === ref_sel, "R2 select state", 32'(box_sel), 32'(ref_sel));
      if (!ref_sel) begin
         chk({h_oe, s_oe, a_oe} === 4'b0, "R3 enables low", 32'({h_oe, s_oe, a_oe}), 0);
         chk({h_out, s_out, a_out} === 32'h0, "R3 values zero",
             {h_out, s_out, a_out}, 0);
      end else begin
         if (!rw) begin
            chk({s_oe, h_oe} === 2'b10, "R4 write enables", 32'({s_oe, h_oe}), 32'h2);
            chk(s_out === hdata && h_out === 8'h0, "R4 write data",
                {16'h0, s_out, h_out}, {16'h0, hdata, 8'h0});
         end else begin
            chk({s_oe, h_oe} === 2'b01, "R5 read enables", 32'({s_oe, h_oe}), 32'h1);
            chk(h_out === sdata && s_out === 8'h0, "R5 read data",
                {16'h0, h_out, s_out}, {16'h0, sdata, 8'h0});
         end
         chk(a_out === haddr && a_oe === 2'b11, "R6 address halves",
             {a_oe, 14'h0, a_out}, {2'b11, 14'h0, haddr});
      end
      if (ref_sel && acc)
         chk(dev_n === e_strobe, "R7 device strobe", 32'(dev_n), 32'(e_strobe));
      else
         chk(dev_n === 8'hFF && io_n === 8'hFF, "R9 no strobe",
             {16'h0, dev_n, io_n}, 32'hFFFF);
      chk(io_n === e_strobe, "R8 io strobe matches", 32'(io_n), 32'(e_strobe));
      chk(int_in === e_int && int_tail === e_it, "R10 interrupt chain",
          {23'h0, int_tail, int_in}, {23'h0, e_it, e_int});
      chk(dma_in === e_dma && dma_tail === e_dt, "R11 dma chain",
          {23'h0, dma_tail, dma_in}, {23'h0, e_dt, e_dma});
      chk({phi0_o, phi1_o, q3_o, c7m_o} === {phi0, phi1, q3, c7m}, "R12 clocks",
          32'({phi0_o, phi1_o, q3_o, c7m_o}), 32'({phi0, phi1, q3, c7m}));
   endtask

   task automatic randomize_bus();
      rw    = 1'($urandom);
      acc   = 1'($urandom);
      snum  = 3'($urandom);
      haddr = 16'($urandom);
      hdata = 8'($urandom);
      sdata = 8'($urandom);
      int_head = 1'($urandom);
      dma_head = 1'($urandom);
      int_claim = ($urandom % 3 == 0) ? 8'h0 : 8'(1 << ($urandom % 8)) | 8'($urandom & 8'h80);
      dma_claim = 8'($urandom);
      {phi0, phi1, q3, c7m} = 4'($urandom);
   endtask

   // One cycle: reference update at the edge, new inputs, check mid-cycle.
   task automatic step();
      @(posedge clk);
      if (!rst_n) ref_sel = 0;
      else if (desel_req) ref_sel = 0;
      else if (sel_req) ref_sel = 1;
      #2;
      randomize_bus();
      #2;
      compare_all();
   endtask

   task automatic set_req(input logic s, input logic d);
      sel_req = s;
      desel_req = d;
   endtask

   initial begin : watchdog
      #(2 * CLK_HALF * 200000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      // R1: reset state
      haddr = 16'hBEEF; hdata = 8'h5A; sdata = 8'hA5; acc = 1; rw = 0;
      #3;
      chk(box_sel === 0, "R1 reset select", 32'(box_sel), 0);
      chk({h_oe, s_oe, a_oe} === 4'b0, "R1 reset enables", 32'({h_oe, s_oe, a_oe}), 0);
      chk(dev_n === 8'hFF && io_n === 8'hFF, "R1 reset strobes",
          {16'h0, dev_n, io_n}, 32'hFFFF);
      repeat (2) @(posedge clk);
      #1 rst_n = 1;

      // R3: traffic while deselected
      repeat (20) step();

      // R2: select, then sweep slots for R7/R8 with access on
      set_req(1, 0);
      step();
      set_req(0, 0);
      for (int s = 0; s < NS; s++) begin
         @(posedge clk);
         #2;
         acc = 1; snum = 3'(s); rw = s[0];
         #2;
         compare_all();
      end

      // R10/R11 directed chain patterns
      begin
         logic [7:0] pats [5] = '{8'h00, 8'h01, 8'h80, 8'h24, 8'hFF};
         foreach (pats[i]) begin
            @(posedge clk);
            #2;
            int_head = 1; dma_head = 1;
            int_claim = pats[i]; dma_claim = ~pats[i];
            #2;
            compare_all();
         end
      end

      // R2: both requests together -> deselect wins
      set_req(1, 1);
      step();
      set_req(0, 0);
      step();

      // Mixed random run with occasional requests
      for (int n = 0; n < 600; n++) begin
         int r = int'($urandom % 16);
         set_req(r == 0 || r == 1, r == 2 || (r == 1 && n[0]));
         step();
      end
      set_req(0, 0);
      step();

      // R1: asynchronous reset mid-run
      #1 rst_n = 0;
      #1;
      chk(box_sel === 0, "R1 reset mid-run", 32'(box_sel), 0);
      ref_sel = 0;
      @(posedge clk);
      #1 rst_n = 1;
      repeat (4) step();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule